// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises system software with a down-counting watchdog. The count is 14 bits wide: a 13-bit magnitude plus a sign bit, read as a 14-bit two's-complement value. A single-cycle slow tick enable input decrements the count by one. A nominal tick period is in the range of about 10 ms to about 29 ms. Software keeps the system alive by writing reload values into the timer register over a simple 32-bit register bus.

The block has two expiry modes. In the lenient mode, the count reaching zero raises a one-cycle non-maskable interrupt request. The count then keeps running into negative values, and at -16 it raises a one-cycle system reset request and restarts from the full-scale value. In the strict mode, any count of zero or below raises the reset request directly. Software can enter the strict mode but cannot leave it. Only a watchdog reset or a block reset leaves it.

Reload writes are filtered: a write whose upper data bits are not all zero has no effect. An accepted value reaches the counter only on the second slow tick after the write, and a read-only busy flag covers that window. A hold and resume input pair freezes counting when software permits it in the lenient mode. A debug-halt input freezes counting in every mode.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the timer register (offset 0) reads 0x1FFF, the control register (offset 4) reads 6, and both request outputs are low.
- R2: Each tick_en pulse, when the counter is not frozen, decrements the 14-bit count by one. Counting wraps through 0 to 0x3FFF (-1), and bit 13 flags a negative value.
- R3: A write to offset 0 with any of data bits 31:14 set changes neither the count nor the busy flag.
- R4: A write to offset 0 with bits 31:14 all zero and busy clear captures bits 12:0 and sets the busy flag (control bit 3). The value is loaded on the second following tick, and that tick does not decrement. Busy then clears. Reload writes made while busy is set are discarded.
- R5: In mode 0 (control bit 0 = 0), nmi_req is high for exactly the one cycle in which the count first holds 0 after a decrement.
- R6: In mode 0, one cycle after the count holds 0x3FF0 (-16), sys_rst_req pulses for one cycle and the count reads 0x1FFF.
- R7: In mode 1, one cycle after the count holds zero or a negative value, sys_rst_req pulses for one cycle and the count reloads to 0x1FFF. nmi_req stays low.
- R8: Writing 1 to control bit 0 sets mode 1. Writing 0 does not clear it. A watchdog reset returns the control register to 6.
- R9: With control bit 2 (hold enable) set and mode 0, hold_req freezes counting and resume_req releases it, with resume taking priority. With hold enable clear, a held state has no effect. In mode 1, hold_req is ignored.
- R10: While dbg_halted is high, ticks do not change the count, in either mode.
- R11: The timer register reads the count in bits 13:0 with bits 31:14 zero. An unmapped offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick, one cycle wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hold_req | input | 1 | Request to freeze counting |
| resume_req | input | 1 | Request to resume counting |
| dbg_halted | input | 1 | Processor halted in debug; freezes counting |
| nmi_req | output | 1 | One-cycle interrupt request pulse |
| sys_rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The embedded assertions check on every cycle the properties that are local to the state:
- the interrupt pulse only appears with a zero count and from the lenient mode, and lasts one cycle;
- a reset pulse always comes with the full-scale count and never with an interrupt;
- the strict mode bit stays set;
- a pending reload is neither replaced nor dropped while busy;
- a debug halt holds the count.

Only the bench scenarios can show the end-to-end behaviours: the exact tick on which a reload lands, the filtered and refused writes, the full walk from zero to -16, and the way the hold enable and the mode gate the freeze request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Bit positions inside the control register (read view)
   localparam int unsigned CTRL_MODE_BIT = 0;
   localparam int unsigned CTRL_ONE_BIT  = 1;
   localparam int unsigned CTRL_HEN_BIT  = 2;
   localparam int unsigned CTRL_BUSY_BIT = 3;

   typedef struct packed {
      logic busy;
      logic hold_en;
      logic fixed_one;
      logic strict;
   } wdt_ctrl_view_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic wr_i,
   input  logic strict_wr_i,
   input  logic hold_en_wr_i,
   input  logic hold_i,
   input  logic resume_i,
   input  logic dbg_i,
   output logic strict_o,
   output logic hold_en_o,
   output logic halt_o
);
   logic strict_q, hold_en_q, held_q;
   logic gate;

   assign gate      = hold_en_q && !strict_q;
   assign strict_o  = strict_q;
   assign hold_en_o = hold_en_q;
   assign halt_o    = dbg_i || (held_q && gate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strict_q  <= 1'b0;
         hold_en_q <= 1'b1;
         held_q    <= 1'b0;
      end else if (clear_i) begin
         strict_q  <= 1'b0;
         hold_en_q <= 1'b1;
         held_q    <= 1'b0;
      end else begin
         if (wr_i) begin
            strict_q  <= strict_q | strict_wr_i;
            hold_en_q <= hold_en_wr_i;
         end
         if (gate) begin
            if (resume_i)    held_q <= 1'b0;
            else if (hold_i) held_q <= 1'b1;
         end
      end
   end

   a_r8_strict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (strict_q && !clear_i) |=> strict_q);
   a_r9_gate_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !clear_i) |=> $stable(held_q));
endmodule

// File: rtl/wdt_reload.sv
module wdt_reload #(
   parameter int unsigned CNT_W          = 13,
   parameter int unsigned HANDOVER_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic             req_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             busy_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o
);
   localparam int unsigned STG_W = (HANDOVER_TICKS > 1) ? $clog2(HANDOVER_TICKS) : 1;
   localparam logic [STG_W-1:0] STG_LAST = STG_W'(HANDOVER_TICKS - 1);

   logic             busy_q;
   logic [CNT_W-1:0] pend_q;
   logic [STG_W-1:0] stage;
   logic             accept;

   assign accept     = req_i && !busy_q;
   assign busy_o     = busy_q;
   assign load_val_o = pend_q;
   assign load_o     = busy_q && tick_i && (stage == STG_LAST);

   generate
      if (HANDOVER_TICKS > 1) begin : g_staged
         logic [STG_W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         stage_q <= '0;
            else if (clear_i || load_o || accept) stage_q <= '0;
            else if (busy_q && tick_i)          stage_q <= stage_q + 1'b1;
         end
         assign stage = stage_q;
      end else begin : g_direct
         assign stage = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
      end else if (clear_i) begin
         busy_q <= 1'b0;
      end else if (load_o) begin
         busy_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         pend_q <= val_i;
      end
   end

   a_r4_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load_o && !clear_i) |=> (busy_q && $stable(pend_q)));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int unsigned CNT_W     = 13,
   parameter int unsigned NEG_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             halt_i,
   input  logic             strict_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W:0]   cnt_o,
   output logic             expire_o,
   output logic             nmi_o,
   output logic             wdrst_o
);
   localparam int unsigned VAL_W = CNT_W + 1;
   localparam logic [VAL_W-1:0] RELOAD   = {1'b0, {CNT_W{1'b1}}};
   localparam logic [VAL_W-1:0] NEG_MARK = VAL_W'((2 ** VAL_W) - NEG_LIMIT);

   logic [VAL_W-1:0] cnt_q, dec;
   logic             nmi_q, rst_q;

   assign dec      = cnt_q - 1'b1;
   assign expire_o = strict_i ? ((cnt_q == '0) || cnt_q[VAL_W-1]) : (cnt_q == NEG_MARK);
   assign cnt_o    = cnt_q;
   assign nmi_o    = nmi_q;
   assign wdrst_o  = rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RELOAD;
         nmi_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         nmi_q <= 1'b0;
         rst_q <= 1'b0;
         if (expire_o) begin
            cnt_q <= RELOAD;
            rst_q <= 1'b1;
         end else if (load_i) begin
            cnt_q <= {1'b0, load_val_i};
         end else if (tick_i && !halt_i) begin
            cnt_q <= dec;
            nmi_q <= (dec == '0) && !strict_i;
         end
      end
   end

   a_r5_nmi_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |-> (cnt_q == '0));
   a_r5_nmi_lenient_only: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |-> $past(!strict_i));
   a_r5_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |=> !nmi_q);
   a_r6_rst_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> (cnt_q == RELOAD));
   a_r7_rst_no_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> !nmi_q);
   a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !expire_o && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
   parameter int unsigned CNT_W          = 13,
   parameter int unsigned NEG_LIMIT      = 16,
   parameter int unsigned HANDOVER_TICKS = 2,
   parameter int unsigned ADDR_W         = 4,
   parameter int unsigned DATA_W         = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              hold_req,
   input  logic              resume_req,
   input  logic              dbg_halted,
   output logic              nmi_req,
   output logic              sys_rst_req
);
   import wdt_pkg::*;

   localparam int unsigned VAL_W = CNT_W + 1;
   localparam logic [ADDR_W-1:0] OFS_TIMER = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(4);

   generate
      if (VAL_W > DATA_W) begin : g_bad_width
         $error("count does not fit the data bus");
      end
      if (NEG_LIMIT < 1 || NEG_LIMIT >= (2 ** CNT_W)) begin : g_bad_limit
         $error("negative limit out of range");
      end
      if (HANDOVER_TICKS < 1) begin : g_bad_handover
         $error("handover needs at least one tick");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address too narrow for both offsets");
      end
   endgenerate

   logic             wr_timer, wr_ctrl, guard_ok;
   logic             strict, hold_en, halt, busy, load, expire;
   logic [CNT_W-1:0] load_val;
   logic [VAL_W-1:0] cnt;
   wdt_ctrl_view_t   view;

   assign guard_ok = ~|reg_wdata[DATA_W-1:VAL_W];
   assign wr_timer = reg_we && (reg_addr == OFS_TIMER) && guard_ok;
   assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);

   wdt_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (expire),
      .wr_i         (wr_ctrl),
      .strict_wr_i  (reg_wdata[CTRL_MODE_BIT]),
      .hold_en_wr_i (reg_wdata[CTRL_HEN_BIT]),
      .hold_i       (hold_req),
      .resume_i     (resume_req),
      .dbg_i        (dbg_halted),
      .strict_o     (strict),
      .hold_en_o    (hold_en),
      .halt_o       (halt)
   );

   wdt_reload #(.CNT_W(CNT_W), .HANDOVER_TICKS(HANDOVER_TICKS)) u_reload (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (expire),
      .tick_i     (tick_en),
      .req_i      (wr_timer),
      .val_i      (reg_wdata[CNT_W-1:0]),
      .busy_o     (busy),
      .load_o     (load),
      .load_val_o (load_val)
   );

   wdt_count #(.CNT_W(CNT_W), .NEG_LIMIT(NEG_LIMIT)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_en),
      .halt_i     (halt),
      .strict_i   (strict),
      .load_i     (load),
      .load_val_i (load_val),
      .cnt_o      (cnt),
      .expire_o   (expire),
      .nmi_o      (nmi_req),
      .wdrst_o    (sys_rst_req)
   );

   assign view = '{busy: busy, hold_en: hold_en, fixed_one: 1'b1, strict: strict};

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_TIMER)     reg_rdata[VAL_W-1:0] = cnt;
      else if (reg_addr == OFS_CTRL) reg_rdata[CTRL_BUSY_BIT:CTRL_MODE_BIT] = view;
   end

   a_r11_timer_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_TIMER) |-> (reg_rdata[DATA_W-1:VAL_W] == '0));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, reg_we = 1'b0, hold_req = 1'b0, resume_req = 1'b0, dbg_halted = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        nmi_req, sys_rst_req;

   int compared = 0, mismatched = 0, cycles = 0;
   bit timed_out = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_two_stage u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold_req(hold_req), .resume_req(resume_req),
      .dbg_halted(dbg_halted), .nmi_req(nmi_req), .sys_rst_req(sys_rst_req)
   );

   // Behavioural reference model
   int m_cnt, m_pend, m_stage;
   bit m_busy, m_mode, m_fen, m_frz, m_nmi, m_rst;

   always @(posedge clk or negedge rst_n) begin : model
      bit fire, halted, loaded, o_busy, o_mode, o_fen;
      if (!rst_n) begin
         m_cnt = 'h1FFF; m_pend = 0; m_stage = 0;
         m_busy = 0; m_mode = 0; m_fen = 1; m_frz = 0; m_nmi = 0; m_rst = 0;
      end else begin
         o_busy = m_busy; o_mode = m_mode; o_fen = m_fen;
         fire = o_mode ? (m_cnt == 0 || m_cnt >= 'h2000) : (m_cnt == 'h3FF0);
         m_nmi = 0; m_rst = 0;
         if (fire) begin
            m_cnt = 'h1FFF; m_rst = 1; m_mode = 0; m_fen = 1; m_frz = 0; m_busy = 0; m_stage = 0;
         end else begin
            halted = dbg_halted || (m_frz && o_fen && !o_mode);
            loaded = 0;
            if (tick_en && o_busy) begin
               if (m_stage == 1) begin m_cnt = m_pend; m_busy = 0; m_stage = 0; loaded = 1; end
               else m_stage = 1;
            end
            if (tick_en && !loaded && !halted) begin
               m_cnt = (m_cnt - 1) & 'h3FFF;
               if (m_cnt == 0 && !o_mode) m_nmi = 1;
            end
            if (reg_we && reg_addr == 0 && reg_wdata[31:14] == 0 && !o_busy) begin
               m_pend = int'(reg_wdata & 32'h1FFF); m_busy = 1; m_stage = 0;
            end
            if (reg_we && reg_addr == 4) begin
               m_mode = o_mode | reg_wdata[0]; m_fen = reg_wdata[2];
            end
            if (o_fen && !o_mode) begin
               if (resume_req) m_frz = 0;
               else if (hold_req) m_frz = 1;
            end
         end
      end
   end

   function automatic int m_read(logic [3:0] a);
      if (a == 0) return m_cnt;
      if (a == 4) return (int'(m_busy) << 3) | (int'(m_fen) << 2) | 2 | int'(m_mode);
      return 0;
   endfunction

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         compared++;
         if (reg_rdata != 32'(m_read(reg_addr)) || nmi_req != m_nmi || sys_rst_req != m_rst) begin
            mismatched++;
            $display("FAIL cycle-compare (R2/R5/R6/R7) rdata=%h nmi=%0d rst=%0d expected rdata=%h nmi=%0d rst=%0d",
                     reg_rdata, nmi_req, sys_rst_req, m_read(reg_addr), m_nmi, m_rst);
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(bit t, bit we, logic [3:0] a, logic [31:0] d, bit hs, bit rs, bit dh);
      @(posedge clk); #1;
      tick_en = t; reg_we = we; reg_addr = a; reg_wdata = d;
      hold_req = hs; resume_req = rs; dbg_halted = dh;
   endtask

   task automatic peek(logic [3:0] a, output int v);
      drive(0, 0, a, 0, 0, 0, 0);
      @(negedge clk);
      v = int'(reg_rdata);
   endtask

   task automatic ticks(int n);
      repeat (n) drive(1, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin @(posedge clk); cycles++; end
      timed_out = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      int v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      peek(0, v); chk("R1 timer reset", v, 'h1FFF);
      chk("R1 nmi low", int'(nmi_req), 0);
      chk("R1 rst low", int'(sys_rst_req), 0);
      peek(4, v); chk("R1 ctrl reset", v, 6);

      drive(0, 1, 0, 32'h0000_4005, 0, 0, 0);
      peek(4, v); chk("R3 filtered write no busy", v, 6);
      peek(0, v); chk("R3 filtered write no load", v, 'h1FFF);

      drive(0, 1, 0, 32'h0000_0005, 0, 0, 0);
      peek(4, v); chk("R4 busy set", v, 'hE);
      drive(0, 1, 0, 32'h0000_0009, 0, 0, 0);
      ticks(1);
      peek(0, v); chk("R4 first tick decrements", v, 'h1FFE);
      peek(4, v); chk("R4 still busy", v, 'hE);
      ticks(1);
      peek(0, v); chk("R4 loaded on second tick", v, 5);
      peek(4, v); chk("R4 busy clear", v, 6);

      ticks(5);
      peek(0, v); chk("R5 count zero", v, 0);
      chk("R5 nmi pulse", int'(nmi_req), 1);
      peek(0, v); chk("R5 nmi one cycle", int'(nmi_req), 0);
      ticks(1);
      peek(0, v); chk("R2 wrap to 3FFF", v, 'h3FFF);
      chk("R11 upper bits zero", v >>> 14, 0);
      ticks(15);
      peek(0, v); chk("R6 count at -16", v, 'h3FF0);
      chk("R6 no reset yet", int'(sys_rst_req), 0);
      peek(0, v); chk("R6 reset pulse", int'(sys_rst_req), 1);
      chk("R6 reloaded", v, 'h1FFF);
      peek(0, v); chk("R6 reset one cycle", int'(sys_rst_req), 0);

      drive(0, 0, 0, 0, 1, 0, 0);
      ticks(3);
      peek(0, v); chk("R9 held", v, 'h1FFF);
      drive(0, 1, 4, 32'h0, 0, 0, 0);
      ticks(2);
      peek(0, v); chk("R9 hold enable off", v, 'h1FFD);
      drive(0, 1, 4, 32'h4, 0, 0, 0);
      ticks(2);
      peek(0, v); chk("R9 hold re-enabled", v, 'h1FFD);
      drive(0, 0, 0, 0, 1, 1, 0);
      ticks(2);
      peek(0, v); chk("R9 resume wins", v, 'h1FFB);

      repeat (3) drive(1, 0, 0, 0, 0, 0, 1);
      peek(0, v); chk("R10 debug halt", v, 'h1FFB);

      drive(0, 1, 8, 32'hFFFF_FFFF, 0, 0, 0);
      peek(8, v); chk("R11 unmapped reads zero", v, 0);
      peek(4, v); chk("R11 ctrl untouched", v, 6);
      peek(0, v); chk("R11 timer untouched", v, 'h1FFB);

      drive(0, 1, 0, 32'h0000_0002, 0, 0, 0);
      ticks(2);
      drive(0, 1, 4, 32'h5, 0, 0, 0);
      peek(4, v); chk("R8 strict set", v, 7);
      drive(0, 1, 4, 32'h4, 0, 0, 0);
      peek(4, v); chk("R8 strict sticky", v, 7);
      drive(0, 0, 0, 0, 1, 0, 0);
      ticks(1);
      peek(0, v); chk("R7 hold ignored in strict", v, 1);
      ticks(1);
      peek(0, v); chk("R7 count zero", v, 0);
      chk("R7 no nmi", int'(nmi_req), 0);
      peek(0, v); chk("R7 reset pulse", int'(sys_rst_req), 1);
      chk("R7 reloaded", v, 'h1FFF);
      peek(4, v); chk("R8 ctrl back to default", v, 6);

      repeat (3) @(posedge clk);
      if (!timed_out) begin
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule